// File: doc/BRIEF.md
# USB Endpoint Transmit Fault Controller

This block supervises outgoing packets on a set of USB endpoints and handles the two ways a transmission can fail. The first is a data underrun from the memory side. The controller aborts the packet on the wire by requesting a forced bit-stuffing violation. The second is a missing handshake, reported as a timeout. When retry is enabled for the endpoint, a timeout on the first attempt requests one retransmission. A timeout on that second attempt, or any timeout with retry disabled, is final.

Any failure closes the current transmit buffer with a status flag. It also raises a sticky event bit for that endpoint and parks the endpoint in a halted state. The endpoint leaves the halted state only when a restart command for it arrives. A handshake that arrives in time closes the buffer cleanly. Serial encoding, CRC and DMA are handled elsewhere.

Each endpoint runs its own four-state machine:
- ST_IDLE waits for a buffer start.
- ST_SEND is the first attempt.
- ST_RETRY is the second attempt, and also records that the retry has been used.
- ST_HALT is the stopped state after an error.

The transitions are:
- IDLE to SEND on start.
- SEND or RETRY to IDLE on handshake.
- SEND to RETRY on timeout with retry enabled.
- SEND or RETRY to HALT on underrun or on a final timeout.
- HALT to IDLE on restart.

Every strobe produces its registered response on the clock edge that samples it.

Top module: `ep_tx_fault_ctl`

## Requirements
- R1: During and right after reset all outputs are 0, every endpoint is in ST_IDLE and no event bit is set.
- R2: An underrun sampled in ST_SEND or ST_RETRY produces a one-cycle stuff_abort pulse for that endpoint on the same edge.
- R3: On underrun the buffer is closed: buf_close=1 with close_un=1 and close_to=0. The endpoint then enters ST_HALT.
- R4: A timeout in ST_SEND with retry_en=1 produces a one-cycle resend_req pulse without closing the buffer, and moves the endpoint to ST_RETRY.
- R5: A timeout in ST_RETRY, or in ST_SEND with retry_en=0, closes the buffer with close_to=1 and close_un=0, and moves the endpoint to ST_HALT.
- R6: A handshake in ST_SEND or ST_RETRY closes the buffer with both flags 0 and returns the endpoint to ST_IDLE.
- R7: The event bit tx_evt[i] is set on any error close of endpoint i. It stays set until evt_clr[i] is written as 1. A set in the same cycle wins over the clear.
- R8: In ST_HALT the start, handshake, underrun and timeout strobes have no effect. A restart_cmd moves the endpoint to ST_IDLE.
- R9: A restart_cmd for an endpoint that is not in ST_HALT is ignored.
- R10: When strobes coincide in ST_SEND or ST_RETRY, underrun takes priority over handshake, and handshake takes priority over timeout.
- R11: Underrun, timeout and handshake strobes sampled in ST_IDLE are ignored, as is a start sampled in ST_SEND or ST_RETRY.
- R12: Endpoints are independent. Bit i of every vector port belongs to endpoint i only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | N_EP | Buffer transmission start strobe, per endpoint |
| tx_underrun | input | N_EP | Memory-side underrun strobe |
| tx_timeout | input | N_EP | Handshake timeout strobe |
| tx_ack | input | N_EP | Handshake received strobe |
| retry_en | input | N_EP | Per-endpoint enable for a single retry on timeout |
| restart_cmd | input | N_EP | Restart-transmit command strobe |
| evt_clr | input | N_EP | Write-1-to-clear for the event bits |
| stuff_abort | output | N_EP | Force a bit-stuffing violation to abort the packet |
| resend_req | output | N_EP | Request a retransmission of the packet |
| buf_close | output | N_EP | Buffer close strobe |
| close_un | output | N_EP | Underrun flag written with the close |
| close_to | output | N_EP | Timeout flag written with the close |
| tx_evt | output | N_EP | Sticky transmit-error event bits |

## Verification
The bench builds the block with the default N_EP=4. This lets it drive directed sequences on one endpoint while the other three sit in different states, which exposes any crosstalk between endpoints. The full retry-then-fail path, halted-state strobe masking and coincident-strobe priority are each reached by a short directed sequence. A long run of sparse random strobes on all four endpoints then covers retry_en changing between attempts and clears that coincide with new errors.

// File: rtl/ep_txf_pkg.sv
package ep_txf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_RETRY = 2'd2,
        ST_HALT  = 2'd3
    } txf_state_t;
endpackage

// File: rtl/ep_tx_fsm.sv
module ep_tx_fsm
    import ep_txf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic underrun_i,
    input  logic timeout_i,
    input  logic ack_i,
    input  logic retry_en_i,
    input  logic restart_i,
    output logic abort_o,
    output logic resend_o,
    output logic close_o,
    output logic un_o,
    output logic to_o,
    output logic fault_o
);
    txf_state_t state_q, state_d;
    logic abort_d, resend_d, close_d, un_d, to_d;

    // Next state and next outputs
    always_comb begin
        state_d  = state_q;
        abort_d  = 1'b0;
        resend_d = 1'b0;
        close_d  = 1'b0;
        un_d     = 1'b0;
        to_d     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_SEND;
            end
            ST_SEND, ST_RETRY: begin
                if (underrun_i) begin
                    abort_d = 1'b1;
                    close_d = 1'b1;
                    un_d    = 1'b1;
                    state_d = ST_HALT;
                end else if (ack_i) begin
                    close_d = 1'b1;
                    state_d = ST_IDLE;
                end else if (timeout_i) begin
                    if (state_q == ST_SEND && retry_en_i) begin
                        resend_d = 1'b1;
                        state_d  = ST_RETRY;
                    end else begin
                        close_d = 1'b1;
                        to_d    = 1'b1;
                        state_d = ST_HALT;
                    end
                end
            end
            ST_HALT: begin
                if (restart_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign fault_o = un_d | to_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            abort_o  <= 1'b0;
            resend_o <= 1'b0;
            close_o  <= 1'b0;
            un_o     <= 1'b0;
            to_o     <= 1'b0;
        end else begin
            abort_o  <= abort_d;
            resend_o <= resend_d;
            close_o  <= close_d;
            un_o     <= un_d;
            to_o     <= to_d;
        end
    end
endmodule

// File: rtl/ep_evt_bits.sv
module ep_evt_bits #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] evt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_o <= '0;
        else        evt_o <= (evt_o & ~clr_i) | set_i;
    end
endmodule

// File: rtl/ep_tx_fault_ctl.sv
module ep_tx_fault_ctl #(
    parameter int N_EP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_EP-1:0] tx_start,
    input  logic [N_EP-1:0] tx_underrun,
    input  logic [N_EP-1:0] tx_timeout,
    input  logic [N_EP-1:0] tx_ack,
    input  logic [N_EP-1:0] retry_en,
    input  logic [N_EP-1:0] restart_cmd,
    input  logic [N_EP-1:0] evt_clr,
    output logic [N_EP-1:0] stuff_abort,
    output logic [N_EP-1:0] resend_req,
    output logic [N_EP-1:0] buf_close,
    output logic [N_EP-1:0] close_un,
    output logic [N_EP-1:0] close_to,
    output logic [N_EP-1:0] tx_evt
);
    logic [N_EP-1:0] fault_now;

    for (genvar g = 0; g < N_EP; g++) begin : g_ep
        ep_tx_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .start_i    (tx_start[g]),
            .underrun_i (tx_underrun[g]),
            .timeout_i  (tx_timeout[g]),
            .ack_i      (tx_ack[g]),
            .retry_en_i (retry_en[g]),
            .restart_i  (restart_cmd[g]),
            .abort_o    (stuff_abort[g]),
            .resend_o   (resend_req[g]),
            .close_o    (buf_close[g]),
            .un_o       (close_un[g]),
            .to_o       (close_to[g]),
            .fault_o    (fault_now[g])
        );
    end

    ep_evt_bits #(.N(N_EP)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (fault_now),
        .clr_i (evt_clr),
        .evt_o (tx_evt)
    );
endmodule

// File: rtl/ep_tx_fault_chk.sv
module ep_tx_fault_chk #(
    parameter int N_EP = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_EP-1:0] evt_clr,
    input logic [N_EP-1:0] stuff_abort,
    input logic [N_EP-1:0] resend_req,
    input logic [N_EP-1:0] buf_close,
    input logic [N_EP-1:0] close_un,
    input logic [N_EP-1:0] close_to,
    input logic [N_EP-1:0] tx_evt
);
    // R2: an abort always comes with an underrun close
    a_r2_abort_with_un_close: assert property (@(posedge clk) disable iff (!rst_n)
        (stuff_abort & ~(buf_close & close_un)) == '0);

    // R3: the two status flags never appear together
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (close_un & close_to) == '0);

    // R4: a retransmission request never closes the buffer
    a_r4_resend_keeps_open: assert property (@(posedge clk) disable iff (!rst_n)
        (resend_req & buf_close) == '0);

    // R5: a status flag only appears with a close strobe
    a_r5_flag_needs_close: assert property (@(posedge clk) disable iff (!rst_n)
        ((close_un | close_to) & ~buf_close) == '0);

    // R7: an error close is visible in the event bits
    a_r7_error_sets_evt: assert property (@(posedge clk) disable iff (!rst_n)
        ((close_un | close_to) & ~tx_evt) == '0);

    // R7: a set event bit survives until it is cleared
    a_r7_evt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_evt) & ~$past(evt_clr) & ~tx_evt) == '0);
endmodule

bind ep_tx_fault_ctl ep_tx_fault_chk #(.N_EP(N_EP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_clr     (evt_clr),
    .stuff_abort (stuff_abort),
    .resend_req  (resend_req),
    .buf_close   (buf_close),
    .close_un    (close_un),
    .close_to    (close_to),
    .tx_evt      (tx_evt)
);

// File: tb/ep_tx_fault_ctl_test.sv
module ep_tx_fault_ctl_test;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] st = '0, ur = '0, tmo = '0, ack = '0, ren = '0, rs = '0, clr = '0;
    logic [N-1:0] abort_w, resend_w, close_w, un_w, to_w, evt_w;

    int checks = 0;
    int errors = 0;
    string phase = "R1";
    bit done = 0;

    always #2 clk = ~clk;

    ep_tx_fault_ctl #(.N_EP(N)) uut (
        .clk(clk), .rst_n(rst_n),
        .tx_start(st), .tx_underrun(ur), .tx_timeout(tmo), .tx_ack(ack),
        .retry_en(ren), .restart_cmd(rs), .evt_clr(clr),
        .stuff_abort(abort_w), .resend_req(resend_w), .buf_close(close_w),
        .close_un(un_w), .close_to(to_w), .tx_evt(evt_w)
    );

    // Behavioural reference: 0 idle, 1 first attempt, 2 second attempt, 3 halted
    int mst[N];
    logic [N-1:0] e_ab, e_rq, e_cl, e_un, e_to, e_ev;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < N; e++) mst[e] = 0;
            e_ab = '0; e_rq = '0; e_cl = '0; e_un = '0; e_to = '0; e_ev = '0;
        end else begin
            logic [N-1:0] setv;
            setv = '0;
            e_ab = '0; e_rq = '0; e_cl = '0; e_un = '0; e_to = '0;
            for (int e = 0; e < N; e++) begin
                if (mst[e] == 0) begin
                    if (st[e]) mst[e] = 1;
                end else if (mst[e] == 3) begin
                    if (rs[e]) mst[e] = 0;
                end else if (ur[e]) begin
                    e_ab[e] = 1; e_cl[e] = 1; e_un[e] = 1; setv[e] = 1; mst[e] = 3;
                end else if (ack[e]) begin
                    e_cl[e] = 1; mst[e] = 0;
                end else if (tmo[e]) begin
                    if (mst[e] == 1 && ren[e]) begin
                        e_rq[e] = 1; mst[e] = 2;
                    end else begin
                        e_cl[e] = 1; e_to[e] = 1; setv[e] = 1; mst[e] = 3;
                    end
                end
            end
            e_ev = (e_ev & ~clr) | setv;
        end
    end

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (phase %s) t=%0t actual=%b expected=%b", tag, phase, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("R2 stuff_abort", abort_w, e_ab);
            chk("R4 resend_req", resend_w, e_rq);
            chk("R6 buf_close", close_w, e_cl);
            chk("R3 close_un", un_w, e_un);
            chk("R5 close_to", to_w, e_to);
            chk("R7 tx_evt", evt_w, e_ev);
        end
    end

    task automatic cyc(logic [N-1:0] s, logic [N-1:0] u, logic [N-1:0] t,
                       logic [N-1:0] a, logic [N-1:0] r, logic [N-1:0] c);
        @(negedge clk); #1;
        st = s; ur = u; tmo = t; ack = a; rs = r; clr = c;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc('0, '0, '0, '0, '0, '0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        phase = "R1";
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        idle(2);
        ren = 4'b0010;

        phase = "R11";  // strobes in idle are ignored
        cyc('0, 4'b0001, 4'b0001, 4'b0001, '0, '0);
        idle(2);

        phase = "R6";
        cyc(4'b0001, '0, '0, '0, '0, '0);
        cyc(4'b0001, '0, '0, '0, '0, '0);  // R11 start while sending ignored
        cyc('0, '0, '0, 4'b0001, '0, '0);
        idle(2);

        phase = "R4 R5";  // retry on ep1, then final timeout
        cyc(4'b0010, '0, '0, '0, '0, '0);
        cyc('0, '0, 4'b0010, '0, '0, '0);
        idle(1);
        cyc('0, '0, 4'b0010, '0, '0, '0);
        idle(2);

        phase = "R8";  // halted ep1 ignores strobes until restart
        cyc(4'b0010, 4'b0010, 4'b0010, 4'b0010, '0, '0);
        cyc('0, '0, '0, 4'b0010, '0, '0);
        cyc('0, '0, '0, '0, 4'b0010, '0);
        cyc(4'b0010, '0, '0, '0, '0, '0);
        cyc('0, '0, '0, 4'b0010, '0, '0);
        idle(2);

        phase = "R2 R3 R12";  // underrun on ep2 while ep3 sends
        cyc(4'b1100, '0, '0, '0, '0, '0);
        cyc('0, 4'b0100, '0, '0, '0, '0);
        phase = "R9";  // restart on sending ep3 ignored
        cyc('0, '0, '0, '0, 4'b1000, '0);
        cyc('0, '0, '0, 4'b1000, '0, '0);
        idle(2);

        phase = "R10";  // priority among coincident strobes
        cyc(4'b0011, '0, '0, '0, 4'b0110, '0);
        cyc('0, 4'b0001, 4'b0011, 4'b0011, '0, '0);
        cyc(4'b0001, '0, '0, '0, 4'b0001, '0);
        idle(1);
        cyc(4'b0001, '0, '0, '0, '0, '0);
        cyc('0, '0, 4'b0001, 4'b0001, '0, '0);
        idle(2);

        phase = "R7";  // clear, and set beating clear
        cyc('0, '0, '0, '0, '0, 4'b0100);
        cyc(4'b0100, '0, '0, '0, 4'b0001, '0);
        cyc('0, '0, '0, '0, 4'b0100, '0);
        cyc(4'b0100, '0, '0, '0, '0, '0);
        cyc('0, 4'b0100, '0, '0, '0, 4'b0100);
        idle(2);
        cyc('0, '0, '0, '0, '0, 4'b1111);
        idle(2);

        phase = "R12 random";
        for (int i = 0; i < 4000; i++) begin
            logic [N-1:0] s, u, t, a, r, c;
            for (int e = 0; e < N; e++) begin
                s[e] = ($urandom_range(0, 3) == 0);
                u[e] = ($urandom_range(0, 15) == 0);
                t[e] = ($urandom_range(0, 5) == 0);
                a[e] = ($urandom_range(0, 4) == 0);
                r[e] = ($urandom_range(0, 6) == 0);
                c[e] = ($urandom_range(0, 7) == 0);
            end
            if (i % 50 == 0) ren = N'($urandom);
            cyc(s, u, t, a, r, c);
        end
        idle(3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule